// File: doc/BRIEF.md
# Dual-Port Byte RAM with Collision Arbitration

This block is a clocked, two-port byte memory with two independent ports, left and right. Each port can read or write any word at any time. The two ports may read the same word in the same cycle without interfering. If both enabled ports target one word and at least one of them is writing, an arbiter chooses a winner. The winner is the port that was already sitting on that address. The other port gets an active-low busy flag, its write is dropped and its read output stays frozen.

Each port has the following inputs: an active-low select, a read/write level (high means read), an active-low output enable, an address and write data. It returns registered read data and a registered busy flag. There are no pads. A disabled read output drives all zeros.

Top module: `dpram_arb`

## Requirements
- R1: A port whose select is low and whose read/write level is low writes its data byte into the addressed word at the clock edge, unless R7 applies. The default depth is 1024 words with a 10-bit address, which both ports share.
- R2: A port whose select is low and whose read/write level is high captures the addressed word at the clock edge. The output shows that captured word while select and output enable are both low and read/write is high; at all other times the output is 8'h00.
- R3: Two ports that read the same word in the same cycle both receive its value, and neither busy flag goes low in the following cycle.
- R4: A port arrives late when its address changes to equal the address of the other enabled port, and that other port has held its address for at least one cycle. If at least one of the two is writing, the late port's busy flag goes low one clock later.
- R5: A port arrives late when its select goes low onto an address that the other enabled port already holds. If at least one of the two is writing, the late port's busy flag goes low one clock later.
- R6: If both ports arrive at a contested word in the same cycle, the left port wins and the right busy flag goes low one clock later. The left port keeps winning for as long as the contention lasts without a break.
- R7: A write from the losing port in a contended cycle leaves memory unchanged.
- R8: The losing port captures no read data, so its read output keeps its earlier value until the contention ends.
- R9: The busy flag returns high one clock after the addresses differ, or one clock after the winning port's select goes high.
- R10: After reset both busy flags are high and both read registers hold 8'h00.
- R11: The two busy flags are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_cs_n | input | 1 | Left port select, active low |
| l_rd_wr | input | 1 | Left port direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_din | input | DATA_W | Left port write data |
| l_dout | output | DATA_W | Left port read data, zero when not enabled |
| l_busy_n | output | 1 | Left port busy flag, active low, registered |
| r_cs_n | input | 1 | Right port select, active low |
| r_rd_wr | input | 1 | Right port direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| r_din | input | DATA_W | Right port write data |
| r_dout | output | DATA_W | Right port read data, zero when not enabled |
| r_busy_n | output | 1 | Right port busy flag, active low, registered |

## Verification
The comparison and arbitration happen before the edge, from the port inputs present at that edge. Busy flags, captured read words and memory writes all take effect at that edge. The read output is gated by the enable lines as they stand at that moment. The bench therefore applies inputs on the falling edge and advances its reference model directly after the rising edge. It compares busy flags and read outputs at the following falling edge, so every result is checked exactly one edge after the stimulus that caused it. A dropped write shows up at a later read of the same word, which is also checked one edge after that read.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Port index 0 is left, 1 is right.
  // A running contention keeps its owner; a fresh one goes to the port
  // that had already settled on the address, the left port on a tie.
  function automatic owner_e pick_winner(input logic   cont,
                                         input owner_e own,
                                         input logic [1:0] settled);
    if (cont && (own != OWN_NONE)) return own;
    if (settled == 2'b10)          return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

  function automatic logic same_word(input logic [31:0] a,
                                     input logic [31:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             act,
  input  logic [1:0]             wr,
  input  logic [1:0][ADDR_W-1:0] addr,
  output logic [1:0]             lose,
  output logic                   conflict,
  output logic [1:0]             settled,
  output logic                   cont_q,
  output logic [1:0]             busy_n
);

  logic [1:0]             prev_act;
  logic [1:0][ADDR_W-1:0] prev_addr;
  owner_e                 own_q;
  owner_e                 winner;

  for (genvar p = 0; p < 2; p++) begin : g_settle
    assign settled[p] = act[p] && prev_act[p] &&
                        same_word(32'(addr[p]), 32'(prev_addr[p]));
  end

  assign conflict = (&act) && same_word(32'(addr[0]), 32'(addr[1])) && (|wr);
  assign winner   = pick_winner(cont_q, own_q, settled);
  assign lose[0]  = conflict && (winner == OWN_RIGHT);
  assign lose[1]  = conflict && (winner == OWN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= '0;
      prev_addr <= '0;
      cont_q    <= 1'b0;
      own_q     <= OWN_NONE;
      busy_n    <= 2'b11;
    end else begin
      prev_act  <= act;
      prev_addr <= addr;
      cont_q    <= conflict;
      own_q     <= conflict ? winner : OWN_NONE;
      busy_n    <= ~lose;
    end
  end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic [1:0]             we,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] wdata,
  output logic [1:0][DATA_W-1:0] rword
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rword[p] = mem[addr[p]];
  end

endmodule

// File: rtl/dpr_rdreg.sv
module dpr_rdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              drive,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= word;
  end

  assign dout = drive ? held : '0;

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_rd_wr,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  output logic              l_busy_n,
  input  logic              r_cs_n,
  input  logic              r_rd_wr,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout,
  output logic              r_busy_n
);

  logic [1:0]             act, rd, oe, wr, we, lose, settled, busy_n, cap, drv;
  logic                   conflict, arb_cont;
  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] din, rword, rd_q, dout;

  assign act  = {~r_cs_n, ~l_cs_n};
  assign rd   = {r_rd_wr, l_rd_wr};
  assign oe   = {~r_oe_n, ~l_oe_n};
  assign addr = {r_addr, l_addr};
  assign din  = {r_din, l_din};

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign wr[p]  = act[p] && !rd[p];
    assign we[p]  = wr[p] && !lose[p];
    assign cap[p] = act[p] && rd[p] && !lose[p];
    assign drv[p] = act[p] && rd[p] && oe[p];

    dpr_rdreg #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (cap[p]),
      .drive   (drv[p]),
      .word    (rword[p]),
      .held    (rd_q[p]),
      .dout    (dout[p])
    );
  end

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .wr       (wr),
    .addr     (addr),
    .lose     (lose),
    .conflict (conflict),
    .settled  (settled),
    .cont_q   (arb_cont),
    .busy_n   (busy_n)
  );

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .addr  (addr),
    .wdata (din),
    .rword (rword)
  );

  assign l_dout   = dout[0];
  assign r_dout   = dout[1];
  assign l_busy_n = busy_n[0];
  assign r_busy_n = busy_n[1];

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   l_cs_n,
  input logic                   r_cs_n,
  input logic                   l_rd_wr,
  input logic                   r_rd_wr,
  input logic [ADDR_W-1:0]      l_addr,
  input logic [ADDR_W-1:0]      r_addr,
  input logic                   l_busy_n,
  input logic                   r_busy_n,
  input logic [1:0]             lose,
  input logic                   conflict,
  input logic [1:0]             settled,
  input logic                   arb_cont,
  input logic [1:0][DATA_W-1:0] rd_q
);

  // R11
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R4
  l_busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_busy_n) |-> $past(!l_cs_n && !r_cs_n && (l_addr == r_addr)));

  // R5
  r_busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_busy_n) |-> $past(!l_cs_n && !r_cs_n && (l_addr == r_addr)));

  // R6
  tie_goes_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !arb_cont && (settled[0] == settled[1])) |-> (lose == 2'b10));

  // R8
  l_frozen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lose[0] |=> $stable(rd_q[0]));

  // R8
  r_frozen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lose[1] |=> $stable(rd_q[1]));

  // R3
  shared_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !r_cs_n && l_rd_wr && r_rd_wr && (l_addr == r_addr))
      |=> (l_busy_n && r_busy_n));

  // R9
  release_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_addr != r_addr) |=> (l_busy_n && r_busy_n));

endmodule

bind dpram_arb dpr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .l_cs_n   (l_cs_n),
  .r_cs_n   (r_cs_n),
  .l_rd_wr  (l_rd_wr),
  .r_rd_wr  (r_rd_wr),
  .l_addr   (l_addr),
  .r_addr   (r_addr),
  .l_busy_n (l_busy_n),
  .r_busy_n (r_busy_n),
  .lose     (lose),
  .conflict (conflict),
  .settled  (settled),
  .arb_cont (arb_cont),
  .rd_q     (rd_q)
);

// File: tb/sim_dpram_arb.sv
module sim_dpram_arb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_rd_wr = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_rd_wr = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_din = '0, r_din = '0;
  logic [DW-1:0] l_dout, r_dout;
  logic l_busy_n, r_busy_n;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_rd_wr(l_rd_wr), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_din(l_din), .l_dout(l_dout), .l_busy_n(l_busy_n),
    .r_cs_n(r_cs_n), .r_rd_wr(r_rd_wr), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_din(r_din), .r_dout(r_dout), .r_busy_n(r_busy_n)
  );

  // reference model state
  logic [DW-1:0] m_mem [1 << AW];
  logic [DW-1:0] m_rd_l = '0, m_rd_r = '0;
  logic m_busy_l = 1'b1, m_busy_r = 1'b1;
  logic m_pact_l = 1'b0, m_pact_r = 1'b0;
  logic [AW-1:0] m_paddr_l = '0, m_paddr_r = '0;
  logic m_cont = 1'b0, m_left_owns = 1'b1;

  function automatic logic [DW-1:0] shown(input logic cs_n, input logic oe_n,
                                          input logic rdwr, input logic [DW-1:0] q);
    return (!cs_n && !oe_n && rdwr) ? q : '0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic model_edge();
    logic al, ar, wl, wr_, hit, sl, sr, lw, ll, lr;
    al  = !l_cs_n;  ar = !r_cs_n;
    wl  = al && !l_rd_wr;  wr_ = ar && !r_rd_wr;
    hit = al && ar && (l_addr == r_addr) && (wl || wr_);
    sl  = al && m_pact_l && (l_addr == m_paddr_l);
    sr  = ar && m_pact_r && (r_addr == m_paddr_r);
    if (hit && m_cont) lw = m_left_owns;
    else               lw = !(sr && !sl);
    ll = hit && !lw;
    lr = hit && lw;
    if (al && l_rd_wr && !ll) m_rd_l = m_mem[l_addr];
    if (ar && r_rd_wr && !lr) m_rd_r = m_mem[r_addr];
    if (wl && !ll)  m_mem[l_addr] = l_din;
    if (wr_ && !lr) m_mem[r_addr] = r_din;
    m_busy_l = !ll;  m_busy_r = !lr;
    m_cont = hit;  m_left_owns = lw;
    m_pact_l = al;  m_pact_r = ar;
    m_paddr_l = l_addr;  m_paddr_r = r_addr;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    chk(tag, "l_busy_n", DW'(l_busy_n), DW'(m_busy_l));
    chk(tag, "r_busy_n", DW'(r_busy_n), DW'(m_busy_r));
    chk(tag, "l_dout", l_dout, shown(l_cs_n, l_oe_n, l_rd_wr, m_rd_l));
    chk(tag, "r_dout", r_dout, shown(r_cs_n, r_oe_n, r_rd_wr, m_rd_r));
    // R11
    chk("R11", "both busy", DW'(!l_busy_n && !r_busy_n), '0);
  endtask

  task automatic drv_l(input logic cs_n, input logic rdwr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    l_cs_n = cs_n; l_rd_wr = rdwr; l_oe_n = 1'b0; l_addr = a; l_din = d;
  endtask

  task automatic drv_r(input logic cs_n, input logic rdwr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    r_cs_n = cs_n; r_rd_wr = rdwr; r_oe_n = 1'b0; r_addr = a; r_din = d;
  endtask

  task automatic idle();
    drv_l(1'b1, 1'b1, '0, '0);
    drv_r(1'b1, 1'b1, 10'd512, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "l_busy_n", DW'(l_busy_n), 8'h01);
    chk("R10", "r_busy_n", DW'(r_busy_n), 8'h01);
    l_oe_n = 1'b0; r_oe_n = 1'b0; l_cs_n = 1'b0; r_cs_n = 1'b0;
    #1;
    chk("R10", "l_dout", l_dout, 8'h00);
    chk("R10", "r_dout", r_dout, 8'h00);
    l_cs_n = 1'b1; r_cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: preload, both ports writing distinct words, including top word
    for (int i = 0; i < 16; i++) begin
      drv_l(1'b0, 1'b0, AW'(i), DW'(i * 7 + 3));
      drv_r(1'b0, 1'b0, 10'd1023 - AW'(i), DW'(8'hA0 + i));
      tick("R1");
    end
    drv_r(1'b0, 1'b1, 10'd1023, '0); drv_l(1'b1, 1'b1, '0, '0);
    tick("R1");

    // R2: read with and without output enable
    drv_l(1'b0, 1'b1, 10'd3, '0); tick("R2");
    l_oe_n = 1'b1; tick("R2");
    l_oe_n = 1'b0; l_cs_n = 1'b1; tick("R2");

    // R3: shared read of one word
    drv_l(1'b0, 1'b1, 10'd4, '0); drv_r(1'b0, 1'b1, 10'd4, '0);
    tick("R3"); tick("R3");
    idle(); tick("R3");

    // R4 and R7: left moves its address onto settled right word and writes
    drv_r(1'b0, 1'b1, 10'd6, '0); drv_l(1'b0, 1'b1, 10'd9, '0);
    tick("R4"); tick("R4");
    drv_l(1'b0, 1'b0, 10'd6, 8'hEE); tick("R4"); tick("R7");
    drv_l(1'b0, 1'b1, 10'd6, '0); drv_r(1'b1, 1'b1, 10'd6, '0);
    tick("R9"); tick("R7");
    idle(); tick("R7");

    // R5: right selects onto a word the left already holds
    drv_l(1'b0, 1'b1, 10'd2, '0); tick("R5"); tick("R5");
    drv_r(1'b0, 1'b0, 10'd2, 8'h55); tick("R5"); tick("R5");
    drv_r(1'b0, 1'b0, 10'd3, 8'h56); tick("R9");
    idle(); tick("R9");

    // R6 and R8: simultaneous arrival, right frozen while left writes
    drv_r(1'b0, 1'b1, 10'd5, '0); tick("R8");
    idle(); tick("R8");
    drv_l(1'b0, 1'b0, 10'd5, 8'h77); drv_r(1'b0, 1'b1, 10'd5, '0);
    tick("R6"); tick("R8");
    l_din = 8'h78; tick("R8");
    l_cs_n = 1'b1; tick("R9"); tick("R8");
    idle(); tick("R9");

    // mixed random traffic over a narrow window to provoke collisions
    for (int n = 0; n < 3000; n++) begin
      drv_l(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
            AW'($urandom_range(0, 7)), DW'($urandom));
      drv_r(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
            AW'($urandom_range(0, 7)), DW'($urandom));
      l_oe_n = 1'($urandom_range(0, 5) == 0);
      r_oe_n = 1'($urandom_range(0, 5) == 0);
      tick("R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule